// File: doc/BRIEF.md
# Phase-Frequency Detector Control with Lock Detection

This block is the digital half of a frequency synthesizer's phase comparator. It watches two pulse trains, the reference pulse and the divided oscillator pulse, and finds the rising edge of each on a fast sampling clock. Two edge-set flip-flops record which edge came first. The first one drives the enable of an external charge pump. Its source enable turns on when the divided edge leads, and its sink enable turns on when the reference edge leads. Both enables are low when the pump should float. Once the later edge arrives, both flip-flops clear together.

A lock detector measures each phase error in sampling-clock cycles. It declares lock after four consecutive comparisons whose error stays below a programmable window. It drops lock on the first clock on which an error reaches the window, without waiting for that comparison to finish. A current-select output follows the lock flag, so the pump runs at high current while the loop acquires and at low current once it has locked.

A 3-bit test code can override the pump. It can force the pump to float, to sink or to source. It also selects what appears on a shared test pin: the lock flag, the raw reference input or the raw divided input.

Top module: `pfd_lock_ctrl`

## Requirements
- R1: A rising edge on `div_in` with no pending reference edge sets the source flip-flop on that clock. A rising edge on `ref_in` with no pending divided edge sets the sink flip-flop. In normal mode the flip-flop shows on `pump_src` or on `pump_snk` (1 = enabled) in the following cycle.
- R2: On the clock at which the later edge is seen, both flip-flops clear. Edges seen on the same clock never enable the pump. The source and sink enables are never high together.
- R3: With `test_code[2:1]` = 00 the pump enables follow the detector, and `test_pin` shows the lock flag.
- R4: With `test_code[2:1]` = 01 both pump enables are 0 (high impedance) whatever the detector does, and `test_pin` shows the lock flag.
- R5: Code 110 holds `pump_snk`=1 and `pump_src`=0. Code 111 holds `pump_src`=1 and `pump_snk`=0. In both cases `test_pin` shows the lock flag.
- R6: Codes 100 and 101 hold both enables at 0. Code 100 puts `ref_in` on `test_pin`, and code 101 puts `div_in` on `test_pin`.
- R7: The phase error is the number of clocks from the leading edge to the lagging edge. A comparison is good when its error is below `lock_window`. `lock_out` rises on the clock that completes the fourth consecutive good comparison.
- R8: `lock_out` falls, and the good-comparison count restarts, on the clock after the running error of a pending comparison reaches `lock_window`. A comparison that completes with an error equal to the window is not good.
- R9: `cur_low` equals the lock flag. It is 0 (high current) from reset and 1 (low current) while the loop is locked.
- R10: During and after reset, both flip-flops and `lock_out` are 0. With a normal code, both enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference pulse |
| div_in | input | 1 | Divided oscillator pulse |
| test_code | input | 3 | Test-mode code |
| lock_window | input | ERR_W | Phase error limit in clocks |
| pump_src | output | 1 | Charge pump source enable |
| pump_snk | output | 1 | Charge pump sink enable |
| lock_out | output | 1 | Lock flag |
| cur_low | output | 1 | Pump current select (1 = low current) |
| test_pin | output | 1 | Shared test output |

## Verification
The hardest case to reach from the ports is losing lock in the middle of a comparison. The loop must first be locked. A leading edge is then applied, and the lagging edge is held back past the window. The bench observes `lock_out` fall while `pump_src` is still on, before the lagging edge arrives. Edges that fall exactly on the window boundary and edges seen on the same clock are placed at chosen sampling edges, so that the count of good comparisons is known exactly.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {PUMP_HIZ = 2'b00, PUMP_SRC = 2'b01, PUMP_SNK = 2'b10} pump_e;
  typedef enum logic [1:0] {TP_LOCK = 2'b00, TP_REF = 2'b01, TP_DIV = 2'b10} tp_sel_e;

  function automatic pump_e pump_pick(input logic [2:0] code, input logic det_src,
                                      input logic det_snk);
    pump_e st;
    case (code)
      3'b000, 3'b001: begin
        if (det_src)      st = PUMP_SRC;
        else if (det_snk) st = PUMP_SNK;
        else              st = PUMP_HIZ;
      end
      3'b110:  st = PUMP_SNK;
      3'b111:  st = PUMP_SRC;
      default: st = PUMP_HIZ;
    endcase
    return st;
  endfunction

  function automatic tp_sel_e tp_pick(input logic [2:0] code);
    tp_sel_e s;
    case (code)
      3'b100:  s = TP_REF;
      3'b101:  s = TP_DIV;
      default: s = TP_LOCK;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/pfd_edge_core.sv
module pfd_edge_core #(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  input  logic             div_in,
  output logic             src_ff,
  output logic             snk_ff,
  output logic             ref_rise,
  output logic             div_rise,
  output logic             cmp_done,
  output logic             active,
  output logic [ERR_W-1:0] err_now
);
  localparam int NUM_IN = 2;
  localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};

  function automatic logic [ERR_W-1:0] sat_inc(input logic [ERR_W-1:0] v);
    return (v == ERR_MAX) ? v : v + 1'b1;
  endfunction

  logic [NUM_IN-1:0] raw;
  logic [NUM_IN-1:0] rise;
  assign raw = {div_in, ref_in};

  for (genvar g = 0; g < NUM_IN; g++) begin : g_edge
    logic d_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) d_q <= 1'b0;
      else        d_q <= raw[g];
    end
    assign rise[g] = raw[g] & ~d_q;
  end

  assign ref_rise = rise[0];
  assign div_rise = rise[1];

  logic src_set, snk_set;
  logic [ERR_W-1:0] cnt_q;

  assign src_set  = src_ff | div_rise;
  assign snk_set  = snk_ff | ref_rise;
  assign cmp_done = src_set & snk_set;
  assign active   = src_ff | snk_ff;
  assign err_now  = active ? sat_inc(cnt_q) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_ff <= 1'b0;
      snk_ff <= 1'b0;
      cnt_q  <= '0;
    end else begin
      src_ff <= src_set & ~cmp_done;
      snk_ff <= snk_set & ~cmp_done;
      cnt_q  <= (active && !cmp_done) ? sat_inc(cnt_q) : '0;
    end
  end
endmodule

// File: rtl/pfd_lock_det.sv
module pfd_lock_det #(
  parameter int ERR_W    = 8,
  parameter int GOOD_CNT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_done,
  input  logic             active,
  input  logic [ERR_W-1:0] err_now,
  input  logic [ERR_W-1:0] lock_window,
  output logic             lock_q,
  output logic             err_bad,
  output logic             cmp_good
);
  localparam int GC_W = $clog2(GOOD_CNT + 1);
  localparam logic [GC_W-1:0] GC_LAST = GC_W'(GOOD_CNT - 1);

  logic [GC_W-1:0] good_q;

  assign err_bad  = (active || cmp_done) && (err_now >= lock_window);
  assign cmp_good = cmp_done && (err_now < lock_window);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_q <= '0;
      lock_q <= 1'b0;
    end else if (err_bad) begin
      good_q <= '0;
      lock_q <= 1'b0;
    end else if (cmp_good) begin
      if (good_q >= GC_LAST) lock_q <= 1'b1;
      else                   good_q <= good_q + 1'b1;
    end
  end
endmodule

// File: rtl/pfd_test_mux.sv
module pfd_test_mux
  import pfd_pkg::*;
(
  input  logic [2:0] test_code,
  input  logic       det_src,
  input  logic       det_snk,
  input  logic       ref_in,
  input  logic       div_in,
  input  logic       lock_q,
  output logic       pump_src,
  output logic       pump_snk,
  output logic       test_pin
);
  pump_e   st;
  tp_sel_e sel;

  assign st       = pump_pick(test_code, det_src, det_snk);
  assign sel      = tp_pick(test_code);
  assign pump_src = (st == PUMP_SRC);
  assign pump_snk = (st == PUMP_SNK);

  always_comb begin
    case (sel)
      TP_REF:  test_pin = ref_in;
      TP_DIV:  test_pin = div_in;
      default: test_pin = lock_q;
    endcase
  end
endmodule

// File: rtl/pfd_lock_ctrl.sv
module pfd_lock_ctrl #(
  parameter int ERR_W    = 8,
  parameter int GOOD_CNT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  input  logic             div_in,
  input  logic [2:0]       test_code,
  input  logic [ERR_W-1:0] lock_window,
  output logic             pump_src,
  output logic             pump_snk,
  output logic             lock_out,
  output logic             cur_low,
  output logic             test_pin
);
  logic src_ff, snk_ff, ref_rise, div_rise, cmp_done, active;
  logic [ERR_W-1:0] err_now;
  logic lock_q, err_bad, cmp_good;

  pfd_edge_core #(.ERR_W(ERR_W)) i_core (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .div_in(div_in),
    .src_ff(src_ff), .snk_ff(snk_ff), .ref_rise(ref_rise), .div_rise(div_rise),
    .cmp_done(cmp_done), .active(active), .err_now(err_now)
  );

  pfd_lock_det #(.ERR_W(ERR_W), .GOOD_CNT(GOOD_CNT)) i_lock (
    .clk(clk), .rst_n(rst_n), .cmp_done(cmp_done), .active(active),
    .err_now(err_now), .lock_window(lock_window), .lock_q(lock_q),
    .err_bad(err_bad), .cmp_good(cmp_good)
  );

  pfd_test_mux i_mux (
    .test_code(test_code), .det_src(src_ff), .det_snk(snk_ff),
    .ref_in(ref_in), .div_in(div_in), .lock_q(lock_q),
    .pump_src(pump_src), .pump_snk(pump_snk), .test_pin(test_pin)
  );

  assign lock_out = lock_q;
  assign cur_low  = lock_q;
endmodule

// File: rtl/pfd_lock_ctrl_chk.sv
module pfd_lock_ctrl_chk #(
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       test_code,
  input logic [ERR_W-1:0] lock_window,
  input logic             pump_src,
  input logic             pump_snk,
  input logic             lock_out,
  input logic             src_ff,
  input logic             snk_ff,
  input logic             ref_rise,
  input logic             div_rise,
  input logic             cmp_done,
  input logic             active,
  input logic [ERR_W-1:0] err_now
);
  a_r1_div_lead_sets_src: assert property (@(posedge clk) disable iff (!rst_n)
    (div_rise && !ref_rise && !snk_ff) |=> src_ff);
  a_r1_ref_lead_sets_snk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_rise && !div_rise && !src_ff) |=> snk_ff);
  a_r2_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_done |=> (!src_ff && !snk_ff));
  a_r2_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(pump_src && pump_snk));
  a_r3_normal_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (test_code[2:1] == 2'b00) |-> (pump_src == src_ff && pump_snk == snk_ff));
  a_r4_forced_off: assert property (@(posedge clk) disable iff (!rst_n)
    (test_code[2:1] == 2'b01 || test_code[2:1] == 2'b10) |-> (!pump_src && !pump_snk));
  a_r5_forced_sink: assert property (@(posedge clk) disable iff (!rst_n)
    (test_code == 3'b110) |-> (pump_snk && !pump_src));
  a_r7_lock_rise_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_out) |-> $past(cmp_done));
  a_r8_lock_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (active && err_now >= lock_window) |=> !lock_out);
endmodule

bind pfd_lock_ctrl pfd_lock_ctrl_chk #(.ERR_W(ERR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .test_code(test_code), .lock_window(lock_window),
  .pump_src(pump_src), .pump_snk(pump_snk), .lock_out(lock_out),
  .src_ff(src_ff), .snk_ff(snk_ff), .ref_rise(ref_rise), .div_rise(div_rise),
  .cmp_done(cmp_done), .active(active), .err_now(err_now)
);

// File: tb/test_pfd_lock_ctrl.sv
module test_pfd_lock_ctrl;
  localparam int ERR_W = 8;
  localparam int NVEC  = 11;
  // vector: {code[2:0], ref, div, exp_src, exp_snk, exp_tp}, applied during reset (lock = 0)
  localparam logic [7:0] VEC [NVEC] = '{
    {3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {3'b000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {3'b001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {3'b010, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {3'b011, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {3'b110, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {3'b111, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {3'b100, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    {3'b100, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {3'b101, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    {3'b101, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0, div_in = 1'b0;
  logic [2:0] test_code = 3'b000;
  logic [ERR_W-1:0] lock_window = 8'd3;
  logic pump_src, pump_snk, lock_out, cur_low, test_pin;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  pfd_lock_ctrl #(.ERR_W(ERR_W), .GOOD_CNT(4)) i_pfd_lock_ctrl (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .div_in(div_in),
    .test_code(test_code), .lock_window(lock_window),
    .pump_src(pump_src), .pump_snk(pump_snk), .lock_out(lock_out),
    .cur_low(cur_low), .test_pin(test_pin)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one comparison: leader rises, lagger rises gap clocks later, both drop, idle
  task automatic compare(input bit div_first, input int gap);
    @(negedge clk);
    if (gap == 0) begin ref_in = 1'b1; div_in = 1'b1; end
    else if (div_first) div_in = 1'b1;
    else ref_in = 1'b1;
    for (int i = 0; i < gap; i++) @(negedge clk);
    ref_in = 1'b1; div_in = 1'b1;
    idle(2);
    ref_in = 1'b0; div_in = 1'b0;
    idle(3);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R3 R4 R5 R6 R10: mux table walked during reset
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      {test_code, ref_in, div_in} = VEC[v][7:3];
      #1;
      chk("R3-mux src", pump_src, VEC[v][2]);
      chk("R5-mux snk", pump_snk, VEC[v][1]);
      chk("R6-mux test_pin", test_pin, VEC[v][0]);
    end
    @(negedge clk);
    test_code = 3'b000; ref_in = 1'b0; div_in = 1'b0;
    chk("R10 lock in reset", lock_out, 1'b0);
    chk("R10 cur in reset", cur_low, 1'b0);
    rst_n = 1'b1;
    idle(2);
    chk("R10 src after reset", pump_src, 1'b0);
    chk("R10 snk after reset", pump_snk, 1'b0);
    chk("R9 high current", cur_low, 1'b0);

    // good 1: divided leads by 2
    @(negedge clk); div_in = 1'b1;
    @(negedge clk);
    chk("R1 src on div lead", pump_src, 1'b1);
    chk("R1 snk off div lead", pump_snk, 1'b0);
    @(negedge clk); ref_in = 1'b1;
    @(negedge clk);
    chk("R2 src cleared", pump_src, 1'b0);
    chk("R2 snk cleared", pump_snk, 1'b0);
    idle(1); ref_in = 1'b0; div_in = 1'b0; idle(3);

    // good 2: reference leads by 1
    @(negedge clk); ref_in = 1'b1;
    @(negedge clk);
    chk("R1 snk on ref lead", pump_snk, 1'b1);
    chk("R1 src off ref lead", pump_src, 1'b0);
    div_in = 1'b1;
    @(negedge clk);
    chk("R2 snk cleared", pump_snk, 1'b0);
    idle(1); ref_in = 1'b0; div_in = 1'b0; idle(3);

    // good 3: simultaneous edges
    @(negedge clk); ref_in = 1'b1; div_in = 1'b1;
    @(negedge clk);
    chk("R2 equal src", pump_src, 1'b0);
    chk("R2 equal snk", pump_snk, 1'b0);
    idle(1); ref_in = 1'b0; div_in = 1'b0; idle(3);
    chk("R7 no lock after 3", lock_out, 1'b0);

    // good 4: error 2 < window 3
    compare(1'b0, 2);
    chk("R7 lock after 4", lock_out, 1'b1);
    chk("R9 low current", cur_low, 1'b1);
    chk("R3 test_pin lock", test_pin, 1'b1);

    // R4: forced off while detector has source pending
    @(negedge clk); test_code = 3'b010; div_in = 1'b1;
    @(negedge clk);
    chk("R4 src forced off", pump_src, 1'b0);
    chk("R4 test_pin lock", test_pin, 1'b1);
    ref_in = 1'b1;
    idle(2); ref_in = 1'b0; div_in = 1'b0; idle(3);
    test_code = 3'b111; #1;
    chk("R5 forced source", pump_src, 1'b1);
    chk("R5 test_pin lock", test_pin, 1'b1);
    test_code = 3'b000;
    chk("R7 lock kept", lock_out, 1'b1);

    // R8: lock drops during a pending comparison
    @(negedge clk); div_in = 1'b1;
    idle(4);
    chk("R8 lock dropped early", lock_out, 1'b0);
    chk("R8 src still pending", pump_src, 1'b1);
    chk("R9 back to high current", cur_low, 1'b0);
    idle(2); ref_in = 1'b1;
    idle(2); ref_in = 1'b0; div_in = 1'b0; idle(3);

    // R7: programmable window 5, error 4 good
    lock_window = 8'd5;
    compare(1'b1, 4); compare(1'b0, 4); compare(1'b1, 4);
    chk("R7 restart no lock after 3", lock_out, 1'b0);
    compare(1'b0, 4);
    chk("R7 lock with window 5", lock_out, 1'b1);

    // R8: error equal to window is bad
    compare(1'b0, 5);
    chk("R8 error equal window", lock_out, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule